// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous host to an external asynchronous static RAM of 2^19 words of 8 bits. The host offers one access at a time through a valid/ready handshake that carries a read/write select, a word address and write data. Read results come back on a data output together with a one-cycle valid strobe. On the memory side the block drives active-low chip-select, write-strobe and output-enable lines, a word address, and a shared bidirectional data bus that it drives only while it writes.

Because the memory has no clock, every strobe edge is placed on a clock edge and every interval is a whole number of cycles. Each count is derived from a nanosecond requirement (write-strobe width, data setup, read access time, output release time, supply settling time) and the clock period, all given as parameters. After reset the block keeps the host waiting until the supply settling time has passed. After every read it keeps all strobes inactive long enough for the memory to stop driving the bus before the next access can begin.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low and all three memory strobes stay high until the power-up count has expired. `req_ready` first reads high after PWR_CYC+1 rising edges, where PWR_CYC = ceil(T_POWERUP_PS / CLK_PERIOD_PS).
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is in progress, and only while all strobes are high.
- R3: A write (`req_write` = 1) holds `mem_ce_n` and `mem_we_n` low together for exactly WE_CYC consecutive cycles. WE_CYC is the larger of the write-strobe count and the data-setup count. `mem_oe_n` stays high throughout, and the address and bus data stay stable across the window. `req_ready` returns WE_CYC edges after acceptance.
- R4: The controller drives `mem_dq` only while `mem_we_n` is low. It never asserts `mem_we_n` and `mem_oe_n` low in the same cycle, and `mem_we_n` is low only together with `mem_ce_n`.
- R5: A read (`req_write` = 0) holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for RD_CYC = ceil(T_READ_PS / CLK_PERIOD_PS) cycles. The bus value is captured on the edge that ends this window.
- R6: `rd_valid` is high for exactly one cycle, RD_CYC edges after the read is accepted, and `rd_data` then carries the word stored at the requested address.
- R7: After every read, all strobes stay high for TURN_CYC = ceil(T_RELEASE_PS / CLK_PERIOD_PS) cycles before `req_ready` rises again. A following write therefore starts only after at least TURN_CYC sampled idle cycles.
- R8: Consecutive writes are separated by at least one cycle with `mem_we_n` high.
- R9: Every cycle count is the ceiling of the time requirement divided by the clock period, and is never less than one.
- R10: `mem_addr` carries the accepted request address for the whole access, so every word written can be read back unchanged at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Controller can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | DATA_W (8) | Write data |
| rd_data | output | DATA_W (8) | Last word read |
| rd_valid | output | 1 | One-cycle strobe for fresh `rd_data` |
| mem_addr | output | ADDR_W (19) | Memory address lines |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq | inout | DATA_W (8) | Bidirectional memory data bus |

## Verification
The bench builds the controller with a 6-bit address, so a sweep can write and read back every word in a few thousand cycles. It declares a clock period of 4 ns, which turns the timing requirements into counts of 2 (write window), 3 (read) and 2 (turnaround), so that an off-by-one in any countdown shows up as a change in measured latency. It sets a 200 ns settling time (50 cycles) so that the power-up wait can be measured exactly. The memory model in the bench returns inverted data until the read window has lasted RD_CYC cycles, flags any write window that is too short, unstable or overlapped by output enable, and flags a write that starts sooner after a read than the release time allows.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state encoding and the time-to-cycles conversion used by
// the asynchronous SRAM controller. Assumes all times are given in ps.
package sram_ctrl_pkg;

    // Access sequencer states
    typedef enum logic [2:0] {
        ST_PWRUP = 3'd0,
        ST_IDLE  = 3'd1,
        ST_WRITE = 3'd2,
        ST_READ  = 3'd3,
        ST_TURN  = 3'd4
    } sram_state_e;

    // Memory strobe bundle, all active low
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } sram_strobe_t;

    localparam sram_strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    // Ceiling of need/period, never below one cycle (R9)
    function automatic int unsigned ps_to_cycles(input int unsigned need_ps,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (need_ps + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwrup_timer.sv
// Power-up wait: counts CYCLES clocks after reset release, then raises done
// and holds it. Assumes CYCLES >= 1.
module sram_pwrup_timer #(
    parameter int unsigned CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Count up to the settling limit once, then hold done (R1)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q  <= cnt_q + 1'b1;
            done_q <= (cnt_q == CNT_W'(CYCLES - 1));
        end
    end

    assign done = done_q;

endmodule

// File: rtl/sram_access_fsm.sv
// Access sequencer: accepts one host request at a time, walks the write,
// read and turnaround windows with a shared down-counter, and produces
// registered memory strobes and the bus-drive enable. Assumes every count
// parameter is at least one.
module sram_access_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned WE_CYC   = 1,
    parameter int unsigned RD_CYC   = 1,
    parameter int unsigned TURN_CYC = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_done,
    input  logic         req_valid,
    input  logic         req_write,
    output logic         req_ready,
    output logic         accept,
    output logic         capture,
    output sram_strobe_t strobe,
    output logic         dq_oe
);
    localparam int unsigned MAX_CYC = max_u(max_u(WE_CYC, RD_CYC), TURN_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    sram_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    sram_strobe_t     strobe_q, strobe_d;
    logic             dq_oe_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    // Next state and window countdown
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        capture = 1'b0;
        case (state_q)
            ST_PWRUP: if (pwr_done) state_d = ST_IDLE;
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = req_write ? ST_WRITE : ST_READ;
                    cnt_d   = req_write ? CNT_W'(WE_CYC - 1) : CNT_W'(RD_CYC - 1);
                end
            end
            ST_WRITE: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_READ: begin
                if (cnt_q == '0) begin
                    capture = 1'b1;
                    state_d = ST_TURN;
                    cnt_d   = CNT_W'(TURN_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_TURN: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobe pattern for the state being entered
    always_comb begin
        strobe_d = STROBE_IDLE;
        case (state_d)
            ST_WRITE: strobe_d = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1};
            ST_READ:  strobe_d = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0};
            default:  strobe_d = STROBE_IDLE;
        endcase
    end

    // State, counter and glitch-free registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_PWRUP;
            cnt_q    <= '0;
            strobe_q <= STROBE_IDLE;
            dq_oe_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            strobe_q <= strobe_d;
            dq_oe_q  <= (state_d == ST_WRITE);
        end
    end

    assign strobe = strobe_q;
    assign dq_oe  = dq_oe_q;

endmodule

// File: rtl/sram_data_path.sv
// Data path: latches the accepted address and write data for the whole
// access, captures the bus on the sequencer's capture pulse and raises a
// one-cycle valid toward the host.
module sram_data_path #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    // Hold address and write data from acceptance to the next acceptance (R10)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture read data and pulse valid for one cycle (R6)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) rdata_q <= dq_in;
        end
    end

    assign mem_addr = addr_q;
    assign wdata    = wdata_q;
    assign rd_data  = rdata_q;
    assign rd_valid = rvalid_q;

endmodule

// File: rtl/sram_async_ctrl.sv
// Top: asynchronous SRAM access controller. Converts the memory's timing
// requirements (ps) into whole-cycle counts for the configured clock period,
// waits out supply settling, then sequences single reads and writes. The
// data bus is driven only inside the write-strobe window.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W          = 19,
    parameter int unsigned DATA_W          = 8,
    parameter int unsigned CLK_PERIOD_PS   = 10000,
    parameter int unsigned T_WE_PULSE_PS   = 7000,
    parameter int unsigned T_DATA_SETUP_PS = 5000,
    parameter int unsigned T_READ_PS       = 10000,
    parameter int unsigned T_RELEASE_PS    = 5000,
    parameter int unsigned T_POWERUP_PS    = 100000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    // Cycle counts derived from the timing requirements (R9)
    localparam int unsigned WE_CYC   = max_u(ps_to_cycles(T_WE_PULSE_PS, CLK_PERIOD_PS),
                                             ps_to_cycles(T_DATA_SETUP_PS, CLK_PERIOD_PS));
    localparam int unsigned RD_CYC   = ps_to_cycles(T_READ_PS, CLK_PERIOD_PS);
    localparam int unsigned TURN_CYC = ps_to_cycles(T_RELEASE_PS, CLK_PERIOD_PS);
    localparam int unsigned PWR_CYC  = ps_to_cycles(T_POWERUP_PS, CLK_PERIOD_PS);

    logic              pwr_done;
    logic              accept;
    logic              capture;
    logic              dq_oe;
    sram_strobe_t      strobe;
    logic [DATA_W-1:0] wdata;

    sram_pwrup_timer #(.CYCLES(PWR_CYC)) pwr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .done (pwr_done)
    );

    sram_access_fsm #(
        .WE_CYC  (WE_CYC),
        .RD_CYC  (RD_CYC),
        .TURN_CYC(TURN_CYC)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_done (pwr_done),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .accept   (accept),
        .capture  (capture),
        .strobe   (strobe),
        .dq_oe    (dq_oe)
    );

    sram_data_path #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) dp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .capture  (capture),
        .dq_in    (mem_dq),
        .mem_addr (mem_addr),
        .wdata    (wdata),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign mem_ce_n = strobe.ce_n;
    assign mem_we_n = strobe.we_n;
    assign mem_oe_n = strobe.oe_n;

    // Tri-state bus driver, active only in the write window (R4)
    assign mem_dq = dq_oe ? wdata : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_async_ctrl_chk.sv
// Checker for the asynchronous SRAM controller: strobe exclusivity, bus
// ownership, minimum window lengths and host-side pulse shape. Window
// lengths are measured with counters rather than long delays.
module sram_async_ctrl_chk #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned WE_CYC = 1,
    parameter int unsigned RD_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dq_oe
);
    int unsigned we_run_q;
    int unsigned rd_run_q;

    // Length of the current low window of each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run_q <= 0;
            rd_run_q <= 0;
        end else begin
            we_run_q <= mem_we_n ? 0 : we_run_q + 1;
            rd_run_q <= mem_oe_n ? 0 : rd_run_q + 1;
        end
    end

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R4
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R4
    AST_DRIVE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !mem_we_n); // R4
    AST_WINDOW_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> dq_oe); // R3
    AST_WE_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run_q >= WE_CYC)); // R3
    AST_RD_MIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (rd_run_q >= RD_CYC)); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R10
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n)); // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6
    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!mem_oe_n)); // R6

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .WE_CYC(WE_CYC),
    .RD_CYC(RD_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_addr (mem_addr),
    .dq_oe    (dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
// Bench: small address space, 4 ns declared period, behavioural memory
// model with timing and contention checks, full write/read-back sweeps.
module sram_async_ctrl_tb_top;
    localparam int AW      = 6;
    localparam int DW      = 8;
    localparam int WORDS   = 1 << AW;
    localparam int PER_PS  = 4000;
    localparam int PWP_PS  = 7000;
    localparam int DS_PS   = 5000;
    localparam int RD_PS   = 10000;
    localparam int REL_PS  = 5000;
    localparam int PWR_PS  = 200000;

    // Expected counts worked out independently (R9)
    localparam int EXP_WE   = ((PWP_PS + PER_PS - 1) / PER_PS > (DS_PS + PER_PS - 1) / PER_PS)
                              ? (PWP_PS + PER_PS - 1) / PER_PS : (DS_PS + PER_PS - 1) / PER_PS;
    localparam int EXP_RD   = (RD_PS + PER_PS - 1) / PER_PS;
    localparam int EXP_TURN = (REL_PS + PER_PS - 1) / PER_PS;
    localparam int EXP_PWR  = (PWR_PS + PER_PS - 1) / PER_PS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n;
    wire  [DW-1:0] mem_dq;

    int n_checks = 0;
    int n_err    = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_PS(PER_PS),
        .T_WE_PULSE_PS(PWP_PS), .T_DATA_SETUP_PS(DS_PS), .T_READ_PS(RD_PS),
        .T_RELEASE_PS(REL_PS), .T_POWERUP_PS(PWR_PS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] mem [WORDS];
    int            we_len = 0;
    logic [AW-1:0] w_addr;
    logic [DW-1:0] w_data;
    bit            w_bad;
    int            rd_age = 0;
    int            gap = 100;
    logic          read_act;

    assign read_act = !mem_ce_n && !mem_oe_n && mem_we_n;
    // Inverted data until the access time has elapsed (R5)
    assign mem_dq = read_act ? ((rd_age >= EXP_RD - 1) ? mem[mem_addr] : ~mem[mem_addr])
                             : {DW{1'bz}};

    initial for (int i = 0; i < WORDS; i++) mem[i] = '0;

    always @(posedge clk) begin
        rd_age <= read_act ? rd_age + 1 : 0;
        if (rst_n) begin
            if (!mem_we_n && mem_ce_n) check(0, "R4 we without ce", 1, 0);
            if (!mem_ce_n && !mem_we_n) begin
                if (we_len == 0) begin
                    w_addr = mem_addr;
                    w_data = mem_dq;
                    w_bad  = 0;
                    check(gap >= EXP_TURN, "R7 read-to-write idle gap", gap, EXP_TURN);
                end else if (mem_addr != w_addr || mem_dq != w_data) begin
                    w_bad = 1;
                end
                if (!mem_oe_n) w_bad = 1;
                we_len++;
            end else if (we_len > 0) begin
                check(we_len == EXP_WE, "R3 write window length", we_len, EXP_WE);
                check(!w_bad, "R3 window stable with oe high", int'(w_bad), 0);
                mem[w_addr] = w_data;
                we_len = 0;
            end
            if (read_act) gap = 0;
            else if (mem_ce_n && mem_we_n && mem_oe_n && gap < 100) gap++;
        end
    end

    // ---------------- host tasks ----------------
    task automatic issue(input bit wr, input int a, input int d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input int d);
        int j;
        issue(1'b1, a, d);
        j = 0;
        while (!req_ready && j < 50) begin @(negedge clk); j++; end
        check(j == EXP_WE, "R3 write ready latency", j, EXP_WE);
    endtask

    task automatic do_read(input int a, input int exp_d);
        int j, vcount, vat;
        logic [DW-1:0] got;
        issue(1'b0, a, 0);
        j = 0; vcount = 0; vat = -1; got = '0;
        while (!req_ready && j < 50) begin
            if (rd_valid) begin vcount++; vat = j; got = rd_data; end
            @(negedge clk); j++;
        end
        check(vcount == 1 && vat == EXP_RD, "R6 valid pulse timing", vat, EXP_RD);
        check(got == DW'(exp_d), "R10 read-back data", int'(got), exp_d);
        check(rd_data == DW'(exp_d), "R6 rd_data held", int'(rd_data), exp_d);
        check(j == EXP_RD + EXP_TURN, "R7 read ready latency", j, EXP_RD + EXP_TURN);
    endtask

    function automatic int pat(input int a, input int pass);
        return (a * 29 + pass * 113 + 7) & 255;
    endfunction

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(0, "watchdog", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // Reset state (R1, R2)
        check(!req_ready, "R1 ready low in reset", int'(req_ready), 0);
        check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset",
              int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
        check(!rd_valid, "R6 no valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        n = 0;
        while (!req_ready && n < 1000) begin
            if (!(mem_ce_n && mem_we_n && mem_oe_n)) check(0, "R1 strobe during power-up", n, 0);
            @(negedge clk); n++;
        end
        check(n == EXP_PWR + 1, "R1 power-up length", n, EXP_PWR + 1);

        // Read of untouched memory returns zero (R5)
        do_read(5, 0);
        // Sweep 1: fill every word, read back ascending (R3, R8, R10)
        for (int a = 0; a < WORDS; a++) do_write(a, pat(a, 1));
        for (int a = 0; a < WORDS; a++) do_read(a, pat(a, 1));
        // Sweep 2: descending read-then-write-then-read, exercising turnaround (R7)
        for (int a = WORDS - 1; a >= 0; a--) begin
            do_read(a, pat(a, 1));
            do_write(a, pat(a, 2));
            do_read(a, pat(a, 2));
        end
        // Boundary words and extreme data patterns (R10)
        do_write(0, 8'hFF);
        do_write(WORDS - 1, 8'h00);
        do_read(0, 8'hFF);
        do_read(WORDS - 1, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule